// File: doc/BRIEF.md
# Erase-Block Protection Register

This block keeps the write-protection state of every erase block in a 2M-word array. The array is laid out as 63 large blocks of 32K words starting at word address zero, followed by 8 small blocks of 4K words at the top of the address space. That makes 71 blocks. Each block has two state bits: a protect bit and a pinned bit. A command sequencer raises a one-cycle strobe together with a target word address and a small operation field. The register then changes the state of the block that contains that address.

The same address also drives a read side, which is purely combinational. It returns the two bits of the addressed block, a 16-bit word for the identifier read path, and a flag that tells erase and program engines whether the addressed block may be modified. A synchronous reset puts every block back to protected and not pinned. Reset is the only way to remove the pinned bit.

Top module: `blk_lock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every block goes to state `lock_bits = 2'b01` (protected, not pinned), whatever its earlier state.
- R2: The protect operation (`cmd_ops[0]`) changes 00 to 01 and 10 to 11. It leaves 01 and 11 unchanged.
- R3: The unprotect operation (`cmd_ops[1]`) changes 01 to 00 and 11 to 10. It leaves 00 and 10 unchanged. It clears the protect bit even when the block is pinned.
- R4: The pin operation (`cmd_ops[2]`) moves any state to 11, so pinning an unprotected block also protects it.
- R5: The pinned bit (`lock_bits[1]`) never goes from 1 to 0 except through reset.
- R6: `wr_allowed` is 1 exactly when the protect bit of the block addressed by `cmd_addr` is 0. It follows the address in the same cycle.
- R7: An address below 21'h1F8000 selects block `cmd_addr[20:15]`. An address at or above it selects block 63 + `cmd_addr[14:12]`. A command changes only the selected block.
- R8: `id_rdata` carries the protect bit on bit 0 and the pinned bit on bit 1. Bits 15 to 2 read 0.
- R9: When more than one bit of `cmd_ops` is set, only one operation is applied. Pin wins over unprotect, and unprotect wins over protect.
- R10: While `cmd_stb` is low, `cmd_ops` is ignored and no block changes. State changes appear one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_ops | input | 3 | Operation field: bit0 protect, bit1 unprotect, bit2 pin |
| cmd_addr | input | 21 | Word address for the command target and for the read side |
| lock_bits | output | 2 | {pinned, protected} of the addressed block |
| id_rdata | output | 16 | Identifier read word for the addressed block |
| wr_allowed | output | 1 | Addressed block may be erased or programmed |

## Verification
The properties assume a few things about the inputs. `rst` is high at time zero. The operation field carries meaning only in cycles where `cmd_stb` is high. The properties that look at the read side one cycle after a command also require `cmd_addr` to be held unchanged across that cycle.

The stimulus keeps within these assumptions. It drives every input on the falling clock edge, holds reset for several cycles before the first command, and keeps each command's address on the bus through the following edge until the result has been sampled.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROT = 2'd1,
    OP_UNPR = 2'd2,
    OP_PIN  = 2'd3
  } lock_op_e;

  // Resolve the operation field into a single operation.
  // Priority: pin, then unprotect, then protect.
  function automatic lock_op_e pick_op(input logic stb, input logic [2:0] ops);
    if (!stb)        return OP_NONE;
    else if (ops[2]) return OP_PIN;
    else if (ops[1]) return OP_UNPR;
    else if (ops[0]) return OP_PROT;
    else             return OP_NONE;
  endfunction

  // State encoding: bit1 = pinned, bit0 = protected.
  function automatic logic [1:0] next_state(input logic [1:0] cur, input lock_op_e op);
    case (op)
      OP_PROT: return {cur[1], 1'b1};
      OP_UNPR: return {cur[1], 1'b0};
      OP_PIN:  return 2'b11;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/blk_addr_decode.sv
module blk_addr_decode #(
  parameter int ADDR_W     = 21,
  parameter int BIG_LOG2   = 15,
  parameter int SMALL_LOG2 = 12,
  parameter int N_BIG      = 63,
  parameter int N_SMALL    = 8,
  parameter int IDX_W      = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int HI_W  = ADDR_W - BIG_LOG2;
  localparam int SUB_W = BIG_LOG2 - SMALL_LOG2;
  localparam int NBLK  = N_BIG + N_SMALL;

  function automatic logic [IDX_W-1:0] map_addr(input logic [ADDR_W-1:0] a);
    logic [HI_W-1:0]  hi;
    logic [SUB_W-1:0] sub;
    hi  = a[ADDR_W-1:BIG_LOG2];
    sub = a[BIG_LOG2-1:SMALL_LOG2];
    if (int'(hi) < N_BIG) return IDX_W'(hi);
    else                  return IDX_W'(N_BIG) + IDX_W'(sub);
  endfunction

  assign idx = map_addr(addr);

  always_comb begin
    assert_idx_range_R7: assert (int'(idx) < NBLK);
  end
endmodule

// File: rtl/lock_cell.sv
module lock_cell
  import blk_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sel,
  input  lock_op_e op,
  output logic [1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)      state <= 2'b01;
    else if (sel) state <= next_state(state, op);
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> state == 2'b01);
  assert_protect_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_PROT) |=> state[0]);
  assert_unprotect_keeps_pin_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_UNPR) |=> (!state[0] && state[1] == $past(state[1])));
  assert_pin_locks_R4: assert property (@(posedge clk) disable iff (rst)
    (sel && op == OP_PIN) |=> state == 2'b11);
  assert_pin_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    state[1] |=> state[1]);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(state));
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 16,
  parameter int BIG_LOG2   = 15,
  parameter int SMALL_LOG2 = 12,
  parameter int N_BIG      = 63,
  parameter int N_SMALL    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [2:0]        cmd_ops,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        lock_bits,
  output logic [DATA_W-1:0] id_rdata,
  output logic              wr_allowed
);
  localparam int NBLK  = N_BIG + N_SMALL;
  localparam int IDX_W = $clog2(NBLK);

  logic [IDX_W-1:0] blk_idx;
  lock_op_e         op_eff;
  logic [NBLK-1:0]  hit;
  logic [1:0]       blk_state [NBLK];

  blk_addr_decode #(
    .ADDR_W(ADDR_W), .BIG_LOG2(BIG_LOG2), .SMALL_LOG2(SMALL_LOG2),
    .N_BIG(N_BIG), .N_SMALL(N_SMALL), .IDX_W(IDX_W)
  ) u_dec (
    .addr(cmd_addr),
    .idx (blk_idx)
  );

  assign op_eff = pick_op(cmd_stb, cmd_ops);

  for (genvar g = 0; g < NBLK; g++) begin : g_cell
    assign hit[g] = (op_eff != OP_NONE) && (blk_idx == IDX_W'(g));
    lock_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .sel  (hit[g]),
      .op   (op_eff),
      .state(blk_state[g])
    );
  end

  assign lock_bits  = blk_state[blk_idx];
  assign wr_allowed = ~lock_bits[0];
  assign id_rdata   = {{(DATA_W-2){1'b0}}, lock_bits};

  assert_single_target_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  assert_pin_blocks_write_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_ops[2]) ##1 $stable(cmd_addr) |-> !wr_allowed);
  assert_pin_beats_unprotect_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_ops[2] && cmd_ops[1]) ##1 $stable(cmd_addr) |-> lock_bits == 2'b11);
  assert_id_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    id_rdata[DATA_W-1:2] == '0);
endmodule

// File: tb/blk_lock_ctrl_tb.sv
module blk_lock_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_stb = 1'b0;
  logic [2:0]  cmd_ops = 3'b000;
  logic [20:0] cmd_addr = '0;
  logic [1:0]  lock_bits;
  logic [15:0] id_rdata;
  logic        wr_allowed;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk; // 250 MHz

  blk_lock_ctrl u_dut (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_ops(cmd_ops),
    .cmd_addr(cmd_addr), .lock_bits(lock_bits), .id_rdata(id_rdata),
    .wr_allowed(wr_allowed)
  );

  // {stb, ops[2:0], addr[20:0], expected state after the edge}
  localparam int NV = 19;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 3'b001, 21'h028123, 2'b01},  // R2 protect on 01: no change
    {1'b1, 3'b010, 21'h028123, 2'b00},  // R3 01 -> 00
    {1'b1, 3'b010, 21'h02FFFF, 2'b00},  // R3 00 stays
    {1'b1, 3'b001, 21'h028000, 2'b01},  // R2 00 -> 01
    {1'b1, 3'b010, 21'h028123, 2'b00},  // R3
    {1'b1, 3'b100, 21'h028123, 2'b11},  // R4 00 -> 11
    {1'b1, 3'b001, 21'h028123, 2'b11},  // R2 11 stays
    {1'b1, 3'b010, 21'h028123, 2'b10},  // R3 11 -> 10, R5 pin kept
    {1'b1, 3'b010, 21'h028123, 2'b10},  // R3 10 stays
    {1'b1, 3'b001, 21'h028123, 2'b11},  // R2 10 -> 11
    {1'b1, 3'b010, 21'h028123, 2'b10},  // R3
    {1'b1, 3'b100, 21'h028123, 2'b11},  // R4 10 -> 11
    {1'b1, 3'b010, 21'h1FFFFF, 2'b00},  // R7 top small block
    {1'b1, 3'b111, 21'h1FFFFF, 2'b11},  // R9 pin wins
    {1'b1, 3'b011, 21'h1FF000, 2'b10},  // R9 unprotect beats protect
    {1'b0, 3'b001, 21'h1FF800, 2'b10},  // R10 no strobe
    {1'b1, 3'b110, 21'h1F8000, 2'b11},  // R9 pin beats unprotect
    {1'b1, 3'b000, 21'h1F7FFF, 2'b01},  // R10 empty op field
    {1'b0, 3'b100, 21'h1F9000, 2'b01}   // R10 ops ignored
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h expected=%h", req, cmd_addr, got, exp);
    end
  endtask

  task automatic peek(input string req, input logic [20:0] a, input logic [1:0] exp);
    @(negedge clk);
    cmd_stb  = 1'b0;
    cmd_addr = a;
    #1;
    check(req, {30'd0, lock_bits}, {30'd0, exp});
    check("R6", {31'd0, wr_allowed}, {31'd0, ~exp[0]});
    check("R8", {16'd0, id_rdata}, {16'd0, 14'd0, exp});
  endtask

  task automatic issue(input logic stb, input logic [2:0] ops, input logic [20:0] a);
    @(negedge clk);
    cmd_stb  = stb;
    cmd_ops  = ops;
    cmd_addr = a;
    @(posedge clk);
    #1;
    cmd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: state after reset
    peek("R1", 21'h000000, 2'b01);
    peek("R1", 21'h1F7FFF, 2'b01);
    peek("R1", 21'h1FFFFF, 2'b01);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      issue(v[26], v[25:23], v[22:2]);
      check($sformatf("R2/R3/R4/R9/R10 vec%0d", i), {30'd0, lock_bits}, {30'd0, v[1:0]});
      check("R6", {31'd0, wr_allowed}, {31'd0, ~v[0]});
      check("R8", {16'd0, id_rdata}, {16'd0, 14'd0, v[1:0]});
    end
    // R7: neighbours of touched blocks are unaffected
    peek("R7", 21'h020000, 2'b01);
    peek("R7", 21'h030000, 2'b01);
    peek("R7", 21'h1FE000, 2'b01);

    // R1/R5: reset clears pinned blocks
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    peek("R1 R5", 21'h028123, 2'b01);
    peek("R1 R5", 21'h1FFFFF, 2'b01);
    peek("R1 R5", 21'h1F8000, 2'b01);

    // R7: decoder boundaries
    issue(1'b1, 3'b010, 21'h1F7FFF);  // block 62
    peek("R7", 21'h1F0000, 2'b00);
    peek("R7", 21'h1F8000, 2'b01);
    issue(1'b1, 3'b010, 21'h1F9ABC);  // block 64
    peek("R7", 21'h1F9000, 2'b00);
    peek("R7", 21'h1F8FFF, 2'b01);
    peek("R7", 21'h1FA000, 2'b01);
    issue(1'b1, 3'b010, 21'h000000);  // block 0
    peek("R7", 21'h007FFF, 2'b00);
    peek("R7", 21'h008000, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 got=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule